// File: doc/BRIEF.md
# Error-Corrected Successive-Approximation Conversion Engine

This block sequences one 13-bit successive-approximation conversion for a capacitor-array converter whose mismatch has been measured beforehand. A pulse on `start_i` begins a conversion. In the first cycle the engine reads the stored residual comparator offset from an external 8-word calibration RAM and loads it into an 8-bit signed accumulator. That accumulator drives the correction DAC. The engine then holds the array in sampling for eight cycles. After sampling it runs thirteen bit trials, one per clock, starting with the sign.

During the trials of the seven heaviest capacitors, the engine reads that capacitor's stored error word. While the trial is in progress, the correction DAC shows the accumulator plus that error. When the comparator keeps the bit, the sum becomes the new accumulator value. When it rejects the bit, the previous value stays. The six lightest bits resolve with the correction frozen. At the end the engine registers the result in two's complement and pulses `done_o`.

The analog array, the comparator and the bus interface sit outside the block. The array switch code is in offset binary: code `u` stands for the signed value `u - 4096`. The comparator answers 1 when the sampled input is at or above the level of the code being tried.

Top module: `sar_corr_engine`

## Requirements
- R1: After reset, `done_o`, `result_o`, `corr_o`, `sw_code_o`, `ram_rd_o` and `sample_o` are all zero.
- R2: In the cycle after `start_i` is sampled, the engine reads RAM address 0, which holds the offset word. From the next cycle on, `corr_o` equals that word.
- R3: `sample_o` is high for exactly 8 consecutive cycles, starting 2 cycles after the `start_i` capture edge. No RAM read happens during sampling.
- R4: There are 13 trials, one per clock, in the order offset-binary bit 12 (sign) and then bits 11 down to 0. During each trial, `sw_code_o` equals the bits kept so far with the trial bit set. Bit 12 itself is the bit of highest weight.
- R5: For the trial of offset-binary bit j with 12 >= j >= 6, the engine reads RAM address 13-j. During that trial `corr_o` equals the saturated sum of the accumulator and that word. The sum is stored only when `cmp_i` is 1; otherwise the accumulator is unchanged.
- R6: Each addition saturates to the signed 8-bit range [-128, 127].
- R7: `result_o` is the final offset-binary code with bit 12 inverted. It is two's complement from -4096 (13'h1000) to +4095 (13'h0FFF), and bit 12 is 1 for a negative input.
- R8: `done_o` is a single-cycle pulse 22 clock edges after the `start_i` capture edge. `result_o` changes only together with `done_o`.
- R9: A `start_i` pulse during a conversion abandons it without a `done_o` and starts a new conversion with the R2 to R8 timing.
- R10: During the six lowest trials, `ram_rd_o` is 0 and `corr_o` holds the accumulator. After the conversion, `corr_o` keeps the final accumulated correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a conversion |
| cmp_i | input | 1 | Comparator: input at or above tried level |
| ram_rd_o | output | 1 | Calibration RAM read strobe |
| ram_addr_o | output | 3 | Calibration RAM word address |
| ram_data_i | input | 8 | Calibration RAM read data, signed, same cycle |
| corr_o | output | 8 | Signed correction DAC code |
| sample_o | output | 1 | Array sampling the differential input |
| sw_code_o | output | 13 | Array switch code, offset binary |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 13 | Registered two's-complement result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The correction accumulator is the state the ports see first and most directly. A wrong fetch address, a lost rejection restore or a missing clamp changes `corr_o` within the same trial cycle, so the per-cycle walk catches it at the trial where it happens. A wrong kept-bit register shows on `sw_code_o` at the next trial, and a wrong sequencer count moves `sample_o` or `done_o` by whole cycles. A final-code error reaches `result_o` only at `done_o`. That is why the table of targets also checks the held correction after every conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W    = 13;
  localparam int CORR_W   = 8;
  localparam int N_CAL    = 7;
  localparam int N_SAMPLE = 8;
  localparam int ADDR_W   = 3;
  localparam int IDX_W    = $clog2(RES_W);

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_SAMPLE, PH_TRIAL} phase_t;

  // signed add clamped to the CORR_W range
  function automatic logic signed [CORR_W-1:0] sat_add(
      input logic signed [CORR_W-1:0] a,
      input logic signed [CORR_W-1:0] b);
    logic signed [CORR_W:0] s;
    s = {a[CORR_W-1], a} + {b[CORR_W-1], b};
    if (s[CORR_W] != s[CORR_W-1])
      return s[CORR_W] ? {1'b1, {(CORR_W-1){1'b0}}} : {1'b0, {(CORR_W-1){1'b1}}};
    return s[CORR_W-1:0];
  endfunction

  // offset binary to two's complement
  function automatic logic [RES_W-1:0] to_twos(input logic [RES_W-1:0] u);
    return {~u[RES_W-1], u[RES_W-2:0]};
  endfunction

  function automatic logic [RES_W-1:0] trial_bit(input logic [IDX_W-1:0] idx);
    return RES_W'(1) << idx;
  endfunction

  // heaviest capacitor at address 1, next at 2, ...
  function automatic logic [ADDR_W-1:0] cal_addr(input logic [IDX_W-1:0] idx);
    return ADDR_W'(RES_W - int'(idx));
  endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W   = RES_W,
  parameter int NS  = N_SAMPLE,
  localparam int IW = $clog2(W),
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic [IW-1:0] bit_idx_o,
  output logic          load_o,
  output logic          sample_o,
  output logic          trial_o,
  output logic          last_o
);
  phase_t        ph_q;
  logic [SW-1:0] scnt_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      scnt_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      ph_q   <= PH_LOAD;
      scnt_q <= '0;
      idx_q  <= IW'(W - 1);
    end else begin
      unique case (ph_q)
        PH_LOAD: begin
          ph_q   <= PH_SAMPLE;
          scnt_q <= '0;
        end
        PH_SAMPLE: begin
          if (scnt_q == SW'(NS - 1)) begin
            ph_q  <= PH_TRIAL;
            idx_q <= IW'(W - 1);
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end
        PH_TRIAL: begin
          if (idx_q == '0) ph_q <= PH_IDLE;
          else             idx_q <= idx_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign bit_idx_o = idx_q;
  assign load_o    = (ph_q == PH_LOAD);
  assign sample_o  = (ph_q == PH_SAMPLE);
  assign trial_o   = (ph_q == PH_TRIAL);
  assign last_o    = trial_o && (idx_q == '0);
endmodule

// File: rtl/sar_bits.sv
module sar_bits
  import sar_pkg::*;
#(
  parameter int W   = RES_W,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          trial_i,
  input  logic          last_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  sw_code_o,
  output logic [W-1:0]  result_o,
  output logic          done_o,
  output logic          keep_o
);
  logic [W-1:0] code_q;
  logic [W-1:0] trial_code;

  assign trial_code = code_q | trial_bit(bit_idx_i);
  assign keep_o     = trial_i && cmp_i;
  assign sw_code_o  = trial_i ? trial_code : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        code_q <= '0;
      end else if (trial_i) begin
        if (cmp_i) code_q <= trial_code;
        if (last_i) begin
          result_o <= to_twos(cmp_i ? trial_code : code_q);
          done_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_corr.sv
module sar_corr
  import sar_pkg::*;
#(
  parameter int W   = RES_W,
  parameter int CW  = CORR_W,
  parameter int NC  = N_CAL,
  parameter int AW  = ADDR_W,
  localparam int IW = $clog2(W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 load_i,
  input  logic                 trial_i,
  input  logic [IW-1:0]        bit_idx_i,
  input  logic                 cmp_i,
  input  logic signed [CW-1:0] ram_data_i,
  output logic                 ram_rd_o,
  output logic [AW-1:0]        ram_addr_o,
  output logic signed [CW-1:0] corr_o,
  output logic signed [CW-1:0] acc_o,
  output logic                 cal_trial_o
);
  logic signed [CW-1:0] acc_q;
  logic signed [CW-1:0] tentative;

  assign cal_trial_o = trial_i && (bit_idx_i >= IW'(W - NC));
  assign tentative   = sat_add(acc_q, ram_data_i);
  assign ram_rd_o    = load_i || cal_trial_o;
  assign ram_addr_o  = cal_trial_o ? cal_addr(bit_idx_i) : '0;
  assign corr_o      = cal_trial_o ? tentative : acc_q;
  assign acc_o       = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       acc_q <= '0;
    else if (start_i)                 acc_q <= acc_q;
    else if (load_i)                  acc_q <= ram_data_i;
    else if (cal_trial_o && cmp_i)    acc_q <= tentative;
  end
endmodule

// File: rtl/sar_corr_engine.sv
module sar_corr_engine
  import sar_pkg::*;
#(
  parameter int W  = RES_W,
  parameter int CW = CORR_W,
  parameter int NC = N_CAL,
  parameter int NS = N_SAMPLE,
  parameter int AW = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 cmp_i,
  output logic                 ram_rd_o,
  output logic [AW-1:0]        ram_addr_o,
  input  logic signed [CW-1:0] ram_data_i,
  output logic signed [CW-1:0] corr_o,
  output logic                 sample_o,
  output logic [W-1:0]         sw_code_o,
  output logic                 busy_o,
  output logic [W-1:0]         result_o,
  output logic                 done_o
);
  localparam int IW = $clog2(W);

  logic [IW-1:0]        bit_idx_w;
  logic                 load_w;
  logic                 trial_w;
  logic                 last_w;
  logic                 keep_w;
  logic                 cal_trial_w;
  logic                 low_trial_w;
  logic signed [CW-1:0] acc_w;

  sar_seq #(.W(W), .NS(NS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .bit_idx_o(bit_idx_w), .load_o(load_w), .sample_o(sample_o),
    .trial_o(trial_w), .last_o(last_w)
  );

  sar_bits #(.W(W)) u_bits (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trial_i(trial_w),
    .last_i(last_w), .bit_idx_i(bit_idx_w), .cmp_i(cmp_i),
    .sw_code_o(sw_code_o), .result_o(result_o), .done_o(done_o),
    .keep_o(keep_w)
  );

  sar_corr #(.W(W), .CW(CW), .NC(NC), .AW(AW)) u_corr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_w),
    .trial_i(trial_w), .bit_idx_i(bit_idx_w), .cmp_i(cmp_i),
    .ram_data_i(ram_data_i), .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o),
    .corr_o(corr_o), .acc_o(acc_w), .cal_trial_o(cal_trial_w)
  );

  assign low_trial_w = trial_w && !cal_trial_w;
  assign busy_o      = load_w || sample_o || trial_w;
endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk
  import sar_pkg::*;
#(
  parameter int W  = RES_W,
  parameter int CW = CORR_W,
  parameter int AW = ADDR_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 cmp_i,
  input logic                 ram_rd_o,
  input logic [AW-1:0]        ram_addr_o,
  input logic signed [CW-1:0] ram_data_i,
  input logic signed [CW-1:0] corr_o,
  input logic                 sample_o,
  input logic                 done_o,
  input logic [W-1:0]         result_o,
  input logic                 load_w,
  input logic                 cal_trial_w,
  input logic                 low_trial_w,
  input logic signed [CW-1:0] acc_w
);
  AST_OFS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ram_rd_o && ram_addr_o == '0)); // R2
  AST_OFS_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && !start_i) |=> (corr_o == $past(ram_data_i))); // R2
  AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (!ram_rd_o && !done_o)); // R3
  AST_REJECT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_trial_w && !cmp_i && !start_i) |=> $stable(acc_w)); // R5
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (low_trial_w && !start_i) |=> (!ram_rd_o && $stable(acc_w))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R8
endmodule

bind sar_corr_engine sar_engine_chk #(.W(W), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
  .ram_rd_o(ram_rd_o), .ram_addr_o(ram_addr_o), .ram_data_i(ram_data_i),
  .corr_o(corr_o), .sample_o(sample_o), .done_o(done_o), .result_o(result_o),
  .load_w(load_w), .cal_trial_w(cal_trial_w), .low_trial_w(low_trial_w),
  .acc_w(acc_w)
);

// File: tb/sim_sar_corr_engine.sv
module sim_sar_corr_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, start, cmp, ram_rd, sample, busy, done;
  logic [2:0]        ram_addr;
  logic signed [7:0] ram_data, corr;
  logic [12:0]       sw_code, result;
  logic [12:0]       tgt;
  logic signed [7:0] ram [8];
  int checks = 0;
  int errors = 0;

  assign ram_data = ram[ram_addr];
  assign cmp      = (tgt >= sw_code);

  sar_corr_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .ram_rd_o(ram_rd), .ram_addr_o(ram_addr), .ram_data_i(ram_data),
    .corr_o(corr), .sample_o(sample), .sw_code_o(sw_code), .busy_o(busy),
    .result_o(result), .done_o(done)
  );

  // {target offset-binary, expected two's-complement result}
  localparam logic [25:0] VEC [7] = '{
    {13'h0000, 13'h1000}, {13'h1FFF, 13'h0FFF}, {13'h1000, 13'h0000},
    {13'h0FFF, 13'h1FFF}, {13'h1555, 13'h0555}, {13'h0AAA, 13'h1AAA},
    {13'h1234, 13'h0234}};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp8(input int v);
    return (v > 127) ? 127 : (v < -128) ? -128 : v;
  endfunction

  function automatic int final_corr(input logic [12:0] u);
    int a = ram[0];
    for (int k = 0; k < 7; k++)
      if (u[12-k]) a = clamp8(a + ram[k+1]);
    return a;
  endfunction

  task automatic load_default();
    ram[0] = 3;  ram[1] = 10; ram[2] = -5; ram[3] = 20;
    ram[4] = 1;  ram[5] = -2; ram[6] = 7;  ram[7] = 4;
  endtask

  // launch, return posedge count until done seen
  task automatic run_conv(input logic [12:0] t, output int lat);
    @(negedge clk); tgt = t; start = 1'b1;
    @(posedge clk); lat = 1;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
  endtask

  // cycle-by-cycle walk of one conversion
  task automatic walk(input logic [12:0] t);
    int acc, n, b, tent;
    logic [12:0] code, tc;
    acc = ram[0]; code = '0; n = 0;
    @(negedge clk); tgt = t; start = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0;
    check(ram_rd && ram_addr == 3'd0, "R2", "offset fetch", ram_addr, 0);
    for (int c = 2; c <= 22; c++) begin
      @(posedge clk); n = c;
      @(negedge clk);
      if (c <= 9) begin
        check(sample == 1'b1, "R3", "sampling", sample, 1);
        check(int'(corr) == int'(ram[0]), "R2", "offset applied", corr, ram[0]);
        check(!ram_rd, "R3", "no read in sampling", ram_rd, 0);
      end else begin
        b  = 22 - c;
        tc = code | (13'd1 << b);
        check(!sample, "R3", "sampling over", sample, 0);
        check(sw_code == tc, "R4", "trial code", sw_code, tc);
        if (b >= 6) begin
          tent = clamp8(acc + ram[13-b]);
          check(ram_rd && ram_addr == 3'(13 - b), "R5", "error address", ram_addr, 13 - b);
          check(int'(corr) == tent, "R5", "tentative correction", corr, tent);
          if (t >= tc) acc = tent;
        end else begin
          check(!ram_rd && int'(corr) == acc, "R10", "held correction", corr, acc);
        end
        if (t >= tc) code = tc;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R8", "done at edge 22 after capture", done, 1);
    check(result == {~code[12], code[11:0]}, "R7", "walk result", result,
          {~code[12], code[11:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [12:0] t, e;
    start = 1'b0; tgt = '0; rst_n = 1'b0;
    load_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && result == 0 && corr == 0 && sw_code == 0 && !ram_rd && !sample,
          "R1", "reset state", {done, ram_rd, sample}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 0 && corr == 0, "R1", "idle after reset", result, 0);

    walk(13'h1555);
    walk(13'h0B3C);
    @(negedge clk);
    check(!done, "R8", "done single cycle", done, 0);

    for (int i = 0; i < 7; i++) begin
      t = VEC[i][25:13]; e = VEC[i][12:0];
      run_conv(t, lat);
      check(lat == 23, "R8", "latency", lat, 23);
      check(result == e, "R7", "result code", result, e);
      check(result[12] == (e[12]), "R7", "sign bit", result[12], e[12]);
      check(int'(corr) == final_corr(t), "R5", "final correction", corr, final_corr(t));
    end

    // saturation high
    ram[0] = 100;
    for (int k = 1; k < 8; k++) ram[k] = 127;
    run_conv(13'h1000, lat);
    check(int'(corr) == 127, "R6", "clamp high single add", corr, 127);
    run_conv(13'h1FFF, lat);
    check(int'(corr) == 127, "R6", "clamp high", corr, 127);
    // saturation low
    ram[0] = -100;
    for (int k = 1; k < 8; k++) ram[k] = -128;
    run_conv(13'h1FFF, lat);
    check(int'(corr) == -128, "R6", "clamp low", corr, -128);
    run_conv(13'h0000, lat);
    check(int'(corr) == -100, "R10", "no kept upper bit leaves offset", corr, -100);

    // abort and restart
    load_default();
    @(negedge clk); tgt = 13'h0123; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 0, "R9", "no done before restart", seen, 0);
    end
    run_conv(13'h1ABC, lat);
    check(lat == 23, "R9", "restart latency", lat, 23);
    check(result == 13'h0ABC, "R9", "restart result", result, 13'h0ABC);
    check(int'(corr) == final_corr(13'h1ABC), "R9", "restart correction",
          corr, final_corr(13'h1ABC));

    // result held until next done
    repeat (5) @(negedge clk);
    check(result == 13'h0ABC && !busy, "R8", "result held while idle", result, 13'h0ABC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule